// File: doc/BRIEF.md
# Ingress frame rate policer

This block meters the receive traffic of one switch port and decides, frame by frame, whether a frame is kept or marked for dropping. Each traffic priority has its own credit bucket, measured in bits. A free-running timebase adds the configured rate to every bucket on each tick. At end-of-frame the frame's counted size is compared with the bucket of its priority. If enough credit is present, the frame passes and its size is deducted. If not, the frame is marked for dropping and the bucket is left as it was.

A frame-type selection decides which frames are metered at all. Frames outside the chosen class always pass, are never counted and use no credit. The counted size can include the minimum inter-frame gap and the preamble. A rate of zero means no limit. When the port runs at 10 Mbps, a configured rate above 10 Mbps also means no limit. Per-priority pass and drop counters report how many metered frames were kept and how many were dropped.

Top module: `rx_rate_policer`

## Requirements
- R1: `sel_mode` picks the metered frames: 0 = all frames, 1 = frames with `is_mcast`, 2 = frames with `is_bcast`, 3 = frames with `is_flood`. An unselected frame gets `dec_drop` = 0, changes no counter and uses no credit.
- R2: The counted size in bytes is `frm_len`, plus 12 when `add_ifg` is 1, plus 8 when `add_pre` is 1. The cost in bits is eight times that size.
- R3: For a metered frame of a limited priority, the decision is taken in the cycle `eof` is sampled. If credit >= cost, the frame passes and the cost is deducted. Otherwise `dec_drop` is 1 and the credit is not reduced. `dec_valid`, `dec_drop` and `dec_prio` show the decision in the cycle after that edge.
- R4: A rate setting of 0 means unlimited: `dec_drop` stays 0 and no credit is deducted.
- R5: When `port_10m` is 1, a rate above 10000 kbps means unlimited. A rate of exactly 10000 kbps is still limited.
- R6: A tick first occurs on the TICK_CYCLES-th rising edge after reset is released, and every TICK_CYCLES edges after that. Each tick adds `rate_kbps` bits to the bucket of that priority. When a tick and an end-of-frame fall on the same edge, the decision uses the credit from before the refill.
- R7: Each bucket is full at reset and is capped at (MAX_FRAME + 20) * 8 bits.
- R8: `pass_cnt[p]` and `drop_cnt[p]` count the metered frames of priority p that passed or were dropped. Both counters saturate at all ones.
- R9: While `rst` is 1, `dec_valid` and `dec_drop` are 0 and all counters are 0.
- R10: Priority and class flags are captured when `sof` is 1 and are used at the following `eof`. When `sof` and `eof` are 1 in the same cycle, the current inputs are used. `frm_len` is taken at `eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe; captures priority and class |
| eof | input | 1 | End-of-frame strobe; carries the length |
| frm_len | input | LEN_W | Frame bytes, destination address through FCS |
| frm_prio | input | PRIO_W | Frame priority |
| is_mcast | input | 1 | Frame is multicast |
| is_bcast | input | 1 | Frame is broadcast |
| is_flood | input | 1 | Frame is flooded unknown unicast |
| sel_mode | input | 2 | Metered frame class |
| add_ifg | input | 1 | Add 12 gap bytes to the counted size |
| add_pre | input | 1 | Add 8 preamble bytes to the counted size |
| port_10m | input | 1 | Port runs at 10 Mbps |
| rate_kbps | input | NUM_PRIO*RATE_W | Per-priority rate in kbps; 0 = unlimited |
| dec_valid | output | 1 | A decision is presented |
| dec_drop | output | 1 | The frame is to be dropped |
| dec_prio | output | PRIO_W | Priority of the decided frame |
| pass_cnt | output | NUM_PRIO*CNT_W | Saturating per-priority pass counters |
| drop_cnt | output | NUM_PRIO*CNT_W | Saturating per-priority drop counters |

## Verification
The refill tick and an end-of-frame deduction can land on the same edge of the same bucket. The bench counts clock edges from reset release and places a one-byte frame exactly on the first tick edge of a priority whose bucket is empty. The frame must be dropped, because the decision sees the credit from before the refill. An eight-byte frame on the next edge must then pass on exactly the refilled 64 bits, and a one-byte frame after it must be dropped again.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    localparam int unsigned IFG_BYTES     = 12;
    localparam int unsigned PRE_BYTES     = 8;
    localparam int unsigned OVH_BYTES     = IFG_BYTES + PRE_BYTES;
    localparam int unsigned SLOW_PORT_KBPS = 10000;

    typedef enum logic [1:0] {
        SEL_ALL   = 2'd0,
        SEL_MCAST = 2'd1,
        SEL_BCAST = 2'd2,
        SEL_FLOOD = 2'd3
    } sel_mode_e;

    typedef struct packed {
        logic mcast;
        logic bcast;
        logic flood;
    } frm_class_t;

    function automatic logic class_selected(input sel_mode_e mode, input frm_class_t c);
        logic hit;
        unique case (mode)
            SEL_ALL:   hit = 1'b1;
            SEL_MCAST: hit = c.mcast;
            SEL_BCAST: hit = c.bcast;
            default:   hit = c.flood;
        endcase
        return hit;
    endfunction

    function automatic logic [15:0] counted_bytes(input logic [15:0] len,
                                                  input logic ifg, input logic pre);
        logic [15:0] total;
        total = len;
        if (ifg) total = total + 16'(IFG_BYTES);
        if (pre) total = total + 16'(PRE_BYTES);
        return total;
    endfunction

endpackage

// File: rtl/rxpol_tick.sv
module rxpol_tick #(
    parameter int TICK_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [TW-1:0] phase;

    assign tick = (phase == TW'(TICK_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    generate
        if (TICK_CYCLES > 1) begin : g_gap_chk
            p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick)
                else $error("tick on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/rxpol_frame_track.sv
module rxpol_frame_track
    import rxpol_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic [PRIO_W-1:0] in_prio,
    input  frm_class_t        in_cls,
    output logic [PRIO_W-1:0] cur_prio,
    output frm_class_t        cur_cls
);
    logic [PRIO_W-1:0] held_prio;
    frm_class_t        held_cls;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_prio <= '0;
            held_cls  <= '0;
        end else if (sof) begin
            held_prio <= in_prio;
            held_cls  <= in_cls;
        end
    end

    assign cur_prio = sof ? in_prio : held_prio;
    assign cur_cls  = sof ? in_cls  : held_cls;

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sof |=> (held_prio == $past(held_prio)))
        else $error("captured priority changed without sof");
endmodule

// File: rtl/rxpol_bucket.sv
module rxpol_bucket
    import rxpol_pkg::*;
#(
    parameter int RATE_W   = 17,
    parameter int CRED_W   = 19,
    parameter int CAP_BITS = 12336
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic [RATE_W-1:0] rate,
    input  logic              port_10m,
    input  logic [CRED_W-1:0] cost_bits,
    output logic              limited,
    output logic              ok
);
    localparam int SUM_W = CRED_W + 1;

    logic [CRED_W-1:0] credit;
    logic [CRED_W-1:0] credit_d;
    logic [SUM_W-1:0]  sum;
    logic              take;

    assign limited = (rate != '0) &&
                     !(port_10m && (rate > RATE_W'(SLOW_PORT_KBPS)));
    assign ok      = !limited || (credit >= cost_bits);
    assign take    = req && limited && ok;

    always_comb begin
        sum = SUM_W'(credit);
        if (tick) sum = sum + SUM_W'(rate);
        if (take) sum = sum - SUM_W'(cost_bits);
        if (sum > SUM_W'(CAP_BITS)) credit_d = CRED_W'(CAP_BITS);
        else                        credit_d = sum[CRED_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) credit <= CRED_W'(CAP_BITS);
        else     credit <= credit_d;
    end

    p_credit_cap_r7: assert property (@(posedge clk) disable iff (rst)
        credit <= CRED_W'(CAP_BITS))
        else $error("credit above ceiling");

    p_no_take_on_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (req && !ok) |=> (credit >= $past(credit)))
        else $error("credit reduced by a dropped frame");

    p_exact_take_r3: assert property (@(posedge clk) disable iff (rst)
        (req && ok && limited && !tick) |=> (credit == $past(credit) - $past(cost_bits)))
        else $error("deduction does not match cost");

    p_unlim_no_take_r4: assert property (@(posedge clk) disable iff (rst)
        (req && !limited) |=> (credit >= $past(credit)))
        else $error("unlimited bucket was charged");
endmodule

// File: rtl/rxpol_satcnt.sv
module rxpol_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (inc && (cnt != '1)) cnt <= cnt + 1'b1;
    end

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '1))
        else $error("counter wrapped");

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (inc && (cnt != '1)) |=> (cnt == $past(cnt) + 1'b1))
        else $error("counter missed an increment");
endmodule

// File: rtl/rx_rate_policer.sv
module rx_rate_policer
    import rxpol_pkg::*;
#(
    parameter int NUM_PRIO    = 4,
    parameter int LEN_W       = 11,
    parameter int RATE_W      = 17,
    parameter int CNT_W       = 16,
    parameter int MAX_FRAME   = 1522,
    parameter int TICK_CYCLES = 200000,
    localparam int PRIO_W     = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             sof,
    input  logic                             eof,
    input  logic [LEN_W-1:0]                 frm_len,
    input  logic [PRIO_W-1:0]                frm_prio,
    input  logic                             is_mcast,
    input  logic                             is_bcast,
    input  logic                             is_flood,
    input  logic [1:0]                       sel_mode,
    input  logic                             add_ifg,
    input  logic                             add_pre,
    input  logic                             port_10m,
    input  logic [NUM_PRIO-1:0][RATE_W-1:0]  rate_kbps,
    output logic                             dec_valid,
    output logic                             dec_drop,
    output logic [PRIO_W-1:0]                dec_prio,
    output logic [NUM_PRIO-1:0][CNT_W-1:0]   pass_cnt,
    output logic [NUM_PRIO-1:0][CNT_W-1:0]   drop_cnt
);
    localparam int CAP_BITS = (MAX_FRAME + OVH_BYTES) * 8;
    localparam int CRED_W   = $clog2(CAP_BITS + (1 << RATE_W)) + 1;

    logic              tick;
    logic [PRIO_W-1:0] cur_prio;
    frm_class_t        cur_cls;
    frm_class_t        in_cls;
    logic              metered;
    logic [15:0]       cost_bytes;
    logic [CRED_W-1:0] cost_bits;
    logic [NUM_PRIO-1:0] ok_vec;
    logic [NUM_PRIO-1:0] lim_vec;
    logic              ok_sel;
    logic              lim_sel;

    assign in_cls = '{mcast: is_mcast, bcast: is_bcast, flood: is_flood};

    rxpol_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rxpol_frame_track #(.PRIO_W(PRIO_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .sof      (sof),
        .in_prio  (frm_prio),
        .in_cls   (in_cls),
        .cur_prio (cur_prio),
        .cur_cls  (cur_cls)
    );

    assign metered    = eof && class_selected(sel_mode_e'(sel_mode), cur_cls);
    assign cost_bytes = counted_bytes(16'(frm_len), add_ifg, add_pre);
    assign cost_bits  = CRED_W'({cost_bytes, 3'b000});

    generate
        for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
            logic req;
            assign req = metered && (cur_prio == PRIO_W'(p));

            rxpol_bucket #(
                .RATE_W   (RATE_W),
                .CRED_W   (CRED_W),
                .CAP_BITS (CAP_BITS)
            ) u_bucket (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .req       (req),
                .rate      (rate_kbps[p]),
                .port_10m  (port_10m),
                .cost_bits (cost_bits),
                .limited   (lim_vec[p]),
                .ok        (ok_vec[p])
            );

            rxpol_satcnt #(.W(CNT_W)) u_pass (
                .clk (clk),
                .rst (rst),
                .inc (req && ok_vec[p]),
                .cnt (pass_cnt[p])
            );

            rxpol_satcnt #(.W(CNT_W)) u_drop (
                .clk (clk),
                .rst (rst),
                .inc (req && !ok_vec[p]),
                .cnt (drop_cnt[p])
            );
        end
    endgenerate

    assign ok_sel  = ok_vec[cur_prio];
    assign lim_sel = lim_vec[cur_prio];

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_drop  <= 1'b0;
            dec_prio  <= '0;
        end else begin
            dec_valid <= eof;
            dec_drop  <= metered && !ok_sel;
            dec_prio  <= cur_prio;
        end
    end

    p_unsel_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (eof && !metered) |=> (dec_valid && !dec_drop))
        else $error("unselected frame marked for drop");

    p_zero_rate_r4: assert property (@(posedge clk) disable iff (rst)
        (eof && (rate_kbps[cur_prio] == '0)) |=> !dec_drop)
        else $error("drop with zero rate");

    p_slow_port_r5: assert property (@(posedge clk) disable iff (rst)
        (eof && port_10m && (rate_kbps[cur_prio] > RATE_W'(SLOW_PORT_KBPS))) |=> !dec_drop)
        else $error("drop on 10 Mbps port above line rate");

    p_unlim_sel_r4: assert property (@(posedge clk) disable iff (rst)
        (metered && !lim_sel) |=> !dec_drop)
        else $error("drop on an unlimited priority");

    p_drop_has_valid_r3: assert property (@(posedge clk) disable iff (rst)
        dec_drop |-> dec_valid)
        else $error("drop without a decision");
endmodule

// File: tb/rx_rate_policer_tb.sv
`timescale 1ns/1ps
module rx_rate_policer_tb_top;
    localparam int NP = 4;
    localparam int LW = 11;
    localparam int RW = 17;
    localparam int CW = 3;
    localparam int TC = 1000;
    localparam int PW = 2;
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof = 1'b0, eof = 1'b0;
    logic [LW-1:0] frm_len = '0;
    logic [PW-1:0] frm_prio = '0;
    logic is_mcast = 1'b0, is_bcast = 1'b0, is_flood = 1'b0;
    logic [1:0] sel_mode = 2'd0;
    logic add_ifg = 1'b0, add_pre = 1'b0, port_10m = 1'b0;
    logic [NP-1:0][RW-1:0] rate_kbps;
    logic dec_valid, dec_drop;
    logic [PW-1:0] dec_prio;
    logic [NP-1:0][CW-1:0] pass_cnt, drop_cnt;

    int n_chk = 0, n_fail = 0, edge_n = 0;
    int exp_pass[NP];
    int exp_drop[NP];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) edge_n <= rst ? 0 : edge_n + 1;

    rx_rate_policer #(
        .NUM_PRIO(NP), .LEN_W(LW), .RATE_W(RW), .CNT_W(CW),
        .MAX_FRAME(1522), .TICK_CYCLES(TC)
    ) dut_i (
        .clk(clk), .rst(rst), .sof(sof), .eof(eof), .frm_len(frm_len),
        .frm_prio(frm_prio), .is_mcast(is_mcast), .is_bcast(is_bcast),
        .is_flood(is_flood), .sel_mode(sel_mode), .add_ifg(add_ifg),
        .add_pre(add_pre), .port_10m(port_10m), .rate_kbps(rate_kbps),
        .dec_valid(dec_valid), .dec_drop(dec_drop), .dec_prio(dec_prio),
        .pass_cnt(pass_cnt), .drop_cnt(drop_cnt)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        mc, bc, fl, ifg, pre;
        logic [10:0] len;
        logic        drop, met;
    } vec_t;

    // prio 1, rate 64 kbps, bucket full (12336 bits), no tick during the walk
    localparam vec_t TBL [10] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1000, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1500, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd600,  1'b1, 1'b1},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1500, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd500,  1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd64,   1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd64,   1'b1, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd20,   1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd3,    1'b1, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd2,    1'b0, 1'b1}
    };

    task automatic chk(input bit good, input string rq, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic note(input int p, input logic drop, input logic met);
        if (met) begin
            if (drop) begin if (exp_drop[p] < SAT) exp_drop[p]++; end
            else      begin if (exp_pass[p] < SAT) exp_pass[p]++; end
        end
    endtask

    // starts and ends at a negedge; sof and eof in the same cycle
    task automatic send(input int p, input logic [1:0] m, input logic mc, bc, fl,
                        input logic ifg, pre, input int len,
                        input logic x_drop, x_met, input string rq);
        sof = 1'b1; eof = 1'b1; frm_prio = PW'(p); sel_mode = m;
        is_mcast = mc; is_bcast = bc; is_flood = fl;
        add_ifg = ifg; add_pre = pre; frm_len = LW'(len);
        @(negedge clk);
        sof = 1'b0; eof = 1'b0;
        chk(dec_valid == 1'b1, rq, int'(dec_valid), 1);
        chk(dec_drop == x_drop, rq, int'(dec_drop), int'(x_drop));
        note(p, x_drop, x_met);
    endtask

    task automatic wait_edge(input int n);
        while (edge_n < n - 1) @(negedge clk);
    endtask

    task automatic check_counters(input string rq);
        for (int p = 0; p < NP; p++) begin
            chk(int'(pass_cnt[p]) == exp_pass[p], rq, int'(pass_cnt[p]), exp_pass[p]);
            chk(int'(drop_cnt[p]) == exp_drop[p], rq, int'(drop_cnt[p]), exp_drop[p]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin exp_pass[p] = 0; exp_drop[p] = 0; end
        rate_kbps[0] = RW'(0);
        rate_kbps[1] = RW'(64);
        rate_kbps[2] = RW'(20000);
        rate_kbps[3] = RW'(10000);
        repeat (4) @(negedge clk);

        // R9: reset state
        chk(dec_valid == 1'b0, "R9 valid", int'(dec_valid), 0);
        chk(dec_drop == 1'b0, "R9 drop", int'(dec_drop), 0);
        check_counters("R9 counters");
        rst = 1'b0;

        // R1 R2 R3: table walk on priority 1
        foreach (TBL[i]) begin
            send(1, TBL[i].mode, TBL[i].mc, TBL[i].bc, TBL[i].fl,
                 TBL[i].ifg, TBL[i].pre, int'(TBL[i].len),
                 TBL[i].drop, TBL[i].met, $sformatf("R1 R2 R3 table entry %0d", i));
        end
        chk(dec_prio == 2'd1, "R3 dec_prio", int'(dec_prio), 1);
        check_counters("R8 after table");

        // R5: 10 Mbps port, rate exactly 10000 stays limited (prio 3)
        port_10m = 1'b1;
        send(3, 2'd0, 0, 0, 0, 0, 0, 1500, 1'b0, 1'b1, "R5 10000 first");
        send(3, 2'd0, 0, 0, 0, 0, 0, 1500, 1'b1, 1'b1, "R5 10000 limited");
        // R5: rate above 10000 on a 10 Mbps port is unlimited (prio 2)
        for (int k = 0; k < 3; k++)
            send(2, 2'd0, 0, 0, 0, 0, 0, 1500, 1'b0, 1'b1, "R5 above line rate");
        port_10m = 1'b0;
        send(2, 2'd0, 0, 0, 0, 0, 0, 1500, 1'b0, 1'b1, "R5 100M first");
        send(2, 2'd0, 0, 0, 0, 0, 0, 1500, 1'b1, 1'b1, "R5 100M limited");

        // R10: class and priority captured at sof, used at eof
        sof = 1'b1; frm_prio = 2'd3; is_mcast = 1'b1; sel_mode = 2'd1;
        @(negedge clk);
        sof = 1'b0; frm_prio = 2'd0; is_mcast = 1'b0;
        eof = 1'b1; frm_len = LW'(40); add_ifg = 1'b0; add_pre = 1'b0;
        @(negedge clk);
        eof = 1'b0;
        chk(dec_prio == 2'd3, "R10 captured prio", int'(dec_prio), 3);
        chk(dec_drop == 1'b0, "R10 captured class", int'(dec_drop), 0);
        note(3, 1'b0, 1'b1);
        chk(int'(pass_cnt[3]) == exp_pass[3], "R10 counted under prio 3",
            int'(pass_cnt[3]), exp_pass[3]);

        // R4: rate 0 never drops
        for (int k = 0; k < 3; k++)
            send(0, 2'd0, 0, 0, 0, 0, 0, 1500, 1'b0, 1'b1, "R4 zero rate");

        // R6: tick and eof on the same edge; prio 1 bucket is empty
        wait_edge(TC);
        send(1, 2'd0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, "R6 same-edge uses old credit");
        send(1, 2'd0, 0, 0, 0, 0, 0, 8, 1'b0, 1'b1, "R6 refill of 64 bits");
        send(1, 2'd0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, "R6 refill fully used");

        // R7: ceiling of (1522+20)*8 bits, prio 0 at 80000 kbps
        rate_kbps[0] = RW'(80000);
        wait_edge(3 * TC + 100);
        send(0, 2'd0, 0, 0, 0, 1, 1, 1522, 1'b0, 1'b1, "R7 full bucket equals cost");
        send(0, 2'd0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, "R7 bucket emptied");
        wait_edge(5 * TC + 100);
        send(0, 2'd0, 0, 0, 0, 1, 1, 1522, 1'b0, 1'b1, "R7 refill to ceiling");
        send(0, 2'd0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, "R7 no credit above ceiling");

        // R8: saturation of the pass counter
        rate_kbps[0] = RW'(0);
        for (int k = 0; k < 6; k++)
            send(0, 2'd0, 0, 0, 0, 0, 0, 64, 1'b0, 1'b1, "R8 saturation run");
        chk(int'(pass_cnt[0]) == SAT, "R8 saturated", int'(pass_cnt[0]), SAT);
        check_counters("R8 final");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule